// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block keeps one pending flag per interrupt source: one watchdog source and eight external sources. The flags sit in a 16-bit register. Software reads the register and writes it as a whole word or one byte at a time. A flag is set by a one-cycle event pulse from its source, or by software writing 1 to it. Software writing 0 to a flag clears it. When the CPU acknowledges a source, the hardware clears that source's flag.

The block gates the flags to form a request to the CPU. The watchdog flag is non-maskable: it requests on its own. An external flag requests only when its bit in an internal 8-bit enable register is 1 and the master enable is also 1. Among the live requests, a fixed priority picks the source whose index goes to the CPU.

A software write that raises a flag must not start interrupt entry at once. A two-state hold-off machine handles this. In state `HS_OPEN`, requests pass through. The transition *arm* goes to `HS_HOLD` when a software write puts 1 into any flag bit. In `HS_HOLD`, the transition *rearm* stays in `HS_HOLD` when a further such write arrives. The transition *release* returns to `HS_OPEN` on a retire pulse in a cycle with no such write. All requests are suppressed while the machine is in `HS_HOLD`.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x0000, the enable register is 0, the hold-off machine is in `HS_OPEN`, and `irq_req` and `irq_idx` are 0.
- R2: In `rd_data`, bit 0 is the watchdog flag and bit 8+k is the flag of external source k (k = 0..7). Bits 1 to 7 always read 0, and writes to them have no effect.
- R3: `wr_be[0]` selects bits 7:0 and `wr_be[1]` selects bits 15:8. In a selected byte, each flag bit takes the written value, so 1 sets the flag and 0 clears it. Flags in an unselected byte keep their value.
- R4: A one-cycle pulse on `wdt_evt` or `ext_evt[k]` sets the matching flag on that clock edge. This happens whatever the values of `ext_en` and `master_en`.
- R5: While in `HS_OPEN`, a set watchdog flag raises `irq_req` with `irq_idx` = 0. This holds for any value of `master_en` and of the enable register.
- R6: External flag k takes part in the request only while enable bit k is 1 and `master_en` is 1.
- R7: Index codes are 0 for the watchdog and k+1 for external source k. The watchdog beats every external source, and a lower k beats a higher k. `irq_idx` is 0 whenever `irq_req` is 0.
- R8: When `ack` is 1, the edge clears the flag whose index code equals `ack_idx`. No other flag changes. Codes above 8 clear nothing.
- R9: If an event pulse and an `ack` for the same source fall in the same cycle, the flag is 1 after the edge.
- R10: A write that stores 1 into any flag bit forces `irq_req` to 0 from the next cycle. This lasts until a `retire` pulse is sampled on a later edge. A retire in the same cycle as such a write is not counted. `irq_req` may rise in the cycle after the counted retire.
- R11: When a software write and an `ack` hit the same flag in one cycle, the written value wins. When a software write and an event hit the same flag in one cycle, the flag ends up 1.
- R12: When `en_wr` is 1, `en_wdata` is loaded into the enable register on that edge, with bit k enabling external source k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Flag register write strobe |
| wr_be | input | 2 | Byte lane selects for the write |
| wr_data | input | 16 | Write data for the flag register |
| rd_data | output | 16 | Flag register read value |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| master_en | input | 1 | Master enable for external sources |
| wdt_evt | input | 1 | Watchdog event pulse |
| ext_evt | input | 8 | External event pulses |
| retire | input | 1 | Instruction-retired pulse |
| ack | input | 1 | CPU accepted a request |
| ack_idx | input | 4 | Index code of the accepted source |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 4 | Index code of the winning source |

## Verification
The collision of interest is a clear and a set arriving at the same flag in the same cycle. The clear can be an acknowledge or a software write of 0. The set can be a hardware event or a software write of 1. Directed steps pulse `ext_evt[3]` together with an acknowledge of code 4. They also combine a high-byte write with an event on source 1, and a write of 1 with an acknowledge. A long random phase then lets all four sources of change collide freely. Every clock, a behavioural model in the bench applies the fixed resolution order: acknowledge, then write, then event. The model's flags, request and index are compared with the ports.

// File: rtl/irq_fc_pkg.sv
package irq_fc_pkg;

    typedef enum logic [0:0] {
        HS_OPEN = 1'b0,
        HS_HOLD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
    parameter int IDX_W = 4,
    parameter int ID    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             wr_sel,
    input  logic             wr_bit,
    input  logic             ack,
    input  logic [IDX_W-1:0] ack_idx,
    output logic             q
);
    logic hit_ack;
    logic kept;
    logic nxt;

    always_comb begin
        hit_ack = ack && (ack_idx == IDX_W'(ID));
        kept    = q && !hit_ack;
        // write overrides acknowledge, event overrides both
        nxt     = evt || (wr_sel ? wr_bit : kept);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end
endmodule

// File: rtl/irq_flag_store.sv
module irq_flag_store #(
    parameter int NUM_EXT  = 8,
    parameter int REG_W    = 16,
    parameter int EXT_BASE = 8,
    parameter int IDX_W    = 4,
    localparam int BE_W    = REG_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BE_W-1:0]    wr_be,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               wdt_evt,
    input  logic [NUM_EXT-1:0] ext_evt,
    input  logic               ack,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [REG_W-1:0]   flags_o,
    output logic               sw_set
);
    logic [REG_W-1:0] lane_sel;
    logic [REG_W-1:0] flag_mask;

    genvar b;
    generate
        for (b = 0; b < REG_W; b++) begin : g_bit
            assign lane_sel[b] = wr_en && wr_be[b / 8];
            if (b == 0) begin : g_wdt
                assign flag_mask[b] = 1'b1;
                irq_flag_cell #(.IDX_W(IDX_W), .ID(0)) u_cell (
                    .clk(clk), .rst_n(rst_n), .evt(wdt_evt),
                    .wr_sel(lane_sel[b]), .wr_bit(wr_data[b]),
                    .ack(ack), .ack_idx(ack_idx), .q(flags_o[b])
                );
            end else if (b >= EXT_BASE && b < EXT_BASE + NUM_EXT) begin : g_ext
                assign flag_mask[b] = 1'b1;
                irq_flag_cell #(.IDX_W(IDX_W), .ID(b - EXT_BASE + 1)) u_cell (
                    .clk(clk), .rst_n(rst_n), .evt(ext_evt[b - EXT_BASE]),
                    .wr_sel(lane_sel[b]), .wr_bit(wr_data[b]),
                    .ack(ack), .ack_idx(ack_idx), .q(flags_o[b])
                );
            end else begin : g_rsvd
                assign flag_mask[b] = 1'b0;
                assign flags_o[b]   = 1'b0;
            end
        end
    endgenerate

    assign sw_set = |(wr_data & lane_sel & flag_mask);
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
    parameter int NUM_EXT  = 8,
    parameter int REG_W    = 16,
    parameter int EXT_BASE = 8,
    parameter int IDX_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [NUM_EXT-1:0] en_wdata,
    input  logic               master_en,
    input  logic [REG_W-1:0]   flags,
    output logic               pend_any,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_EXT-1:0] en_q;
    logic [NUM_EXT-1:0] ext_live;

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    always_comb begin
        ext_live = flags[EXT_BASE +: NUM_EXT] & en_q & {NUM_EXT{master_en}};
        win_idx  = '0;
        for (int k = NUM_EXT - 1; k >= 0; k--) begin
            if (ext_live[k]) win_idx = IDX_W'(k + 1);
        end
        if (flags[0]) win_idx = '0;
        pend_any = flags[0] || (|ext_live);
    end
endmodule

// File: rtl/irq_holdoff_fsm.sv
module irq_holdoff_fsm
    import irq_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic retire,
    output logic hold_o
);
    hold_state_e state_q;
    hold_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_OPEN: if (sw_set) state_d = HS_HOLD;          // arm
            HS_HOLD: begin
                if (sw_set)      state_d = HS_HOLD;          // rearm
                else if (retire) state_d = HS_OPEN;          // release
            end
            default:             state_d = HS_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            HS_OPEN: hold_o = 1'b0;
            HS_HOLD: hold_o = 1'b1;
            default: hold_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int NUM_EXT  = 8,
    parameter int REG_W    = 16,
    parameter int EXT_BASE = 8,
    localparam int IDX_W   = $clog2(NUM_EXT + 1),
    localparam int BE_W    = REG_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BE_W-1:0]    wr_be,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               en_wr,
    input  logic [NUM_EXT-1:0] en_wdata,
    input  logic               master_en,
    input  logic               wdt_evt,
    input  logic [NUM_EXT-1:0] ext_evt,
    input  logic               retire,
    input  logic               ack,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx
);
    logic             sw_set;
    logic             hold_w;
    logic             pend_any;
    logic [IDX_W-1:0] win_idx;

    irq_flag_store #(
        .NUM_EXT(NUM_EXT), .REG_W(REG_W), .EXT_BASE(EXT_BASE), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .wdt_evt(wdt_evt), .ext_evt(ext_evt),
        .ack(ack), .ack_idx(ack_idx), .flags_o(rd_data), .sw_set(sw_set)
    );

    irq_prio_gate #(
        .NUM_EXT(NUM_EXT), .REG_W(REG_W), .EXT_BASE(EXT_BASE), .IDX_W(IDX_W)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .master_en(master_en), .flags(rd_data),
        .pend_any(pend_any), .win_idx(win_idx)
    );

    irq_holdoff_fsm u_hold (
        .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .retire(retire),
        .hold_o(hold_w)
    );

    assign irq_req = pend_any && !hold_w;
    assign irq_idx = irq_req ? win_idx : '0;
endmodule

// File: rtl/irq_fc_chk.sv
module irq_fc_chk #(
    parameter int REG_W = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_be0,
    input logic             wr_d0,
    input logic             wdt_evt,
    input logic             master_en,
    input logic             ack,
    input logic [IDX_W-1:0] ack_idx,
    input logic [REG_W-1:0] rd_data,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_idx,
    input logic             hold
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[7:1] == 7'd0); // R2
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n) wdt_evt |=> rd_data[0]); // R4
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[0] && !hold) |-> (irq_req && irq_idx == '0)); // R5
    AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n) (irq_req && irq_idx != '0) |-> master_en); // R6
    AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !irq_req |-> irq_idx == '0); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack && ack_idx == '0 && !wdt_evt && !(wr_en && wr_be0)) |=> !rd_data[0]); // R8
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) hold |-> !irq_req); // R10
    AST_SW_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_be0 && wr_d0) |=> hold); // R10
endmodule

bind irq_flag_ctrl irq_fc_chk #(.REG_W(REG_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be0(wr_be[0]),
    .wr_d0(wr_data[0]), .wdt_evt(wdt_evt), .master_en(master_en),
    .ack(ack), .ack_idx(ack_idx), .rd_data(rd_data),
    .irq_req(irq_req), .irq_idx(irq_idx), .hold(hold_w)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        en_wr;
    logic [7:0]  en_wdata;
    logic        master_en;
    logic        wdt_evt;
    logic [7:0]  ext_evt;
    logic        retire;
    logic        ack;
    logic [3:0]  ack_idx;
    logic        irq_req;
    logic [3:0]  irq_idx;

    int    n_vec  = 0;
    int    n_bad  = 0;
    string tag    = "R1";
    bit    done   = 0;

    logic [15:0] m_flags;
    logic [7:0]  m_en;
    bit          m_hold;

    always #2.5 clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .en_wr(en_wr),
        .en_wdata(en_wdata), .master_en(master_en), .wdt_evt(wdt_evt),
        .ext_evt(ext_evt), .retire(retire), .ack(ack), .ack_idx(ack_idx),
        .irq_req(irq_req), .irq_idx(irq_idx)
    );

    task automatic cmp(input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        int  e_req;
        int  e_idx;
        logic [15:0] nf;
        bit  arm;
        #1.5;
        e_req = 0;
        e_idx = 0;
        if (!m_hold) begin
            if (m_flags[0]) begin
                e_req = 1;
            end else begin
                for (int k = 7; k >= 0; k--)
                    if (m_flags[8+k] && m_en[k] && master_en) begin
                        e_req = 1;
                        e_idx = k + 1;
                    end
            end
        end
        cmp("rd_data", rd_data, m_flags);
        cmp("irq_req", irq_req, e_req);
        cmp("irq_idx", irq_idx, e_idx);
        @(posedge clk);
        if (!rst_n) begin
            m_flags = 0; m_en = 0; m_hold = 0;
        end else begin
            nf  = m_flags;
            arm = 0;
            if (ack && ack_idx == 0) nf[0] = 1'b0;
            else if (ack && ack_idx <= 8) nf[7 + ack_idx] = 1'b0;
            if (wr_en) begin
                for (int b = 0; b < 16; b++) begin
                    if ((b == 0 || b >= 8) && wr_be[b/8]) begin
                        nf[b] = wr_data[b];
                        if (wr_data[b]) arm = 1;
                    end
                end
            end
            if (wdt_evt) nf[0] = 1'b1;
            for (int k = 0; k < 8; k++) if (ext_evt[k]) nf[8+k] = 1'b1;
            if (en_wr) m_en = en_wdata;
            if (arm) m_hold = 1;
            else if (retire) m_hold = 0;
            m_flags = nf;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_be = 0; wr_data = 0; en_wr = 0; en_wdata = 0;
        wdt_evt = 0; ext_evt = 0; retire = 0; ack = 0; ack_idx = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            idle();
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        master_en = 0;
        rst_n = 0;
        m_flags = 0; m_en = 0; m_hold = 0;
        @(negedge clk);
        tag = "R1"; run(3);
        rst_n = 1;
        run(1);

        tag = "R12"; en_wr = 1; en_wdata = 8'hA5; run(1);

        tag = "R2"; wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; run(2);

        tag = "R10"; run(2);
        retire = 1; run(1);
        run(1);
        tag = "R5"; master_en = 0; run(2);

        tag = "R8"; ack = 1; ack_idx = 0; run(2);

        tag = "R6"; master_en = 1; run(1);
        master_en = 0; run(1);
        master_en = 1;

        tag = "R7"; ack = 1; ack_idx = 1; run(1);
        ack = 1; ack_idx = 3; run(1);
        ack = 1; ack_idx = 4'd12; run(1);
        wdt_evt = 1; run(2);

        tag = "R3"; wr_en = 1; wr_be = 2'b01; wr_data = 16'h0000; run(1);
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h0001; run(1);
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h0000; run(2);

        tag = "R4"; en_wr = 1; en_wdata = 8'h00; run(1);
        ext_evt = 8'h42; run(2);

        tag = "R9"; en_wr = 1; en_wdata = 8'hFF; run(1);
        ext_evt = 8'h08; ack = 1; ack_idx = 4; run(2);

        tag = "R11"; wr_en = 1; wr_be = 2'b10; wr_data = 16'h0000; ext_evt = 8'h02; run(1);
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h2000; ack = 1; ack_idx = 6; run(1);
        run(1);

        tag = "R10"; wr_en = 1; wr_be = 2'b01; wr_data = 16'h0001; retire = 1; run(1);
        run(1);
        wr_en = 1; wr_be = 2'b01; wr_data = 16'h0001; retire = 1; run(1);
        retire = 1; run(1);
        run(1);

        tag = "R11";
        for (int i = 0; i < 3000; i++) begin
            wr_en     = ($urandom_range(0, 7) == 0);
            wr_be     = 2'($urandom_range(0, 3));
            wr_data   = 16'($urandom);
            en_wr     = ($urandom_range(0, 15) == 0);
            en_wdata  = 8'($urandom);
            master_en = ($urandom_range(0, 3) != 0);
            wdt_evt   = ($urandom_range(0, 15) == 0);
            ext_evt   = 8'($urandom) & 8'($urandom) & 8'($urandom);
            retire    = ($urandom_range(0, 2) == 0);
            ack       = ($urandom_range(0, 2) == 0);
            ack_idx   = 4'($urandom_range(0, 9));
            tick();
        end
        idle();
        run(2);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule